// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block runs from a synchronous clock and drives an asynchronous page-mode DRAM. Its outputs are the active-low row strobe, column strobe, write enable and output enable, plus one multiplexed address bus. A host hands it one request at a time over a valid/ready handshake. Each request carries a read/write flag, a flat word address and write data. The controller splits the address into a row part and a column part. It opens the row, strobes the column, and keeps the row open so that later requests to the same row need only a column strobe.

Refresh runs on its own. A timer raises a refresh request at a fixed interval. The controller closes any open row, then runs a refresh cycle in which the column strobe falls before the row strobe, so the memory supplies the row address itself. Each minimum time is given in nanoseconds and becomes a whole number of clock cycles, rounded up against the clock-period parameter. Writes are always early writes. Read data comes back to the host with a one-cycle valid strobe.

Top module: `pgdram_ctrl`

## Requirements
- R1: When `dram_ras_n` falls for an access, `dram_addr` carries the row `req_addr[ADDR_W-1:COL_W]`. When `dram_cas_n` falls, it carries the column `req_addr[COL_W-1:0]`. Both are zero-extended into the low bits of the bus.
- R2: `dram_we_n` is high at the column strobe of a read and low at the column strobe of a write. For a write, `dram_we_n` is already low one cycle before `dram_cas_n` falls. `dram_oe_n` stays high while a write holds `dram_cas_n` low. `dram_dq_oe` is only high while `dram_oe_n` is high.
- R3: A request whose row equals the open row is served with a column strobe only, with no new fall of `dram_ras_n`.
- R4: A request to a different row first raises `dram_ras_n`. Every stretch of `dram_ras_n` high that precedes a fall lasts at least N_RP = ceil(T_RP_NS/CLK_NS) cycles.
- R5: `dram_cas_n` stays low for at least N_CAS = ceil(T_CAS_NS/CLK_NS) cycles. Successive column strobe falls within one open row are at least N_PC = ceil(T_PC_NS/CLK_NS) cycles apart.
- R6: `dram_ras_n` stays low for at least N_RAS = ceil((T_RC_NS-T_RP_NS)/CLK_NS) cycles. The first column strobe comes at least N_RCD = ceil(T_RCD_NS/CLK_NS) cycles after the row strobe falls.
- R7: Refresh runs with `dram_cas_n` low at least one cycle before `dram_ras_n` falls. At least one such cycle occurs per N_REFI = ceil(T_REFI_NS/CLK_NS) cycles. A pending refresh closes the open row, so the next request opens its row again.
- R8: Each read returns exactly one `rd_valid` pulse, one cycle wide, with `rd_data` equal to the word the memory drove for that address.
- R9: Reset leaves all four strobes high, `dram_dq_oe` low, `rd_valid` low and `req_ready` high. After a request is accepted, `req_ready` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat word address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the memory |

## Verification
The bench builds the block with a 10 ns clock and the default 12-bit row, 10-bit column and 16-bit data widths. The refresh interval is cut to 3000 ns (300 cycles), so many refresh cycles land between and during host requests. That brings into reach a refresh preempting an open row and a forced reopen afterwards. The timing values give multi-cycle precharge and row-active windows against single-cycle column pulses, and the default data-hold read capture is the variant exercised.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_ACT, S_OPEN, S_CASL, S_CASH, S_CLOSE, S_PRE, S_REFC, S_REFR
   } pg_state_t;

   // nanoseconds to whole cycles, rounded up, never below one
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
      int unsigned c;
      c = (ns + per - 1) / per;
      return (c < 1) ? 1 : c;
   endfunction
endpackage

// File: rtl/pgdram_reftick.sv
module pgdram_reftick #(
   parameter int N_REFI = 1563,
   parameter int CW     = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pend
);
   logic [CW-1:0] cnt;
   logic          expire;

   assign expire = (cnt == CW'(N_REFI - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         cnt  <= expire ? '0 : cnt + 1'b1;
         pend <= (pend & ~ack) | expire;
      end
   end
endmodule

// File: rtl/pgdram_rdcap.sv
module pgdram_rdcap #(
   parameter int DATA_W = 16,
   parameter bit EDO    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              last_lo,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   logic take;

   generate
      if (EDO) begin : g_hold
         // data stays valid after the column strobe rises: sample one cycle later
         logic arm;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) arm <= 1'b0;
            else        arm <= last_lo;
         end
         assign take = arm;
      end else begin : g_fast
         // outputs turn off at the column strobe rise: sample in its last low cycle
         assign take = last_lo;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= take;
         if (take) rd_data <= dq_in;
      end
   end
endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl #(
   parameter int CLK_NS    = 10,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 10,
   parameter int DATA_W    = 16,
   parameter int T_RC_NS   = 84,
   parameter int T_RP_NS   = 30,
   parameter int T_RCD_NS  = 20,
   parameter int T_CAS_NS  = 8,
   parameter int T_PC_NS   = 20,
   parameter int T_REFI_NS = 15625,
   parameter bit EDO       = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_we,
   input  logic [ROW_W+COL_W-1:0] req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   output logic                   rd_valid,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   dram_ras_n,
   output logic                   dram_cas_n,
   output logic                   dram_we_n,
   output logic                   dram_oe_n,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
   output logic [DATA_W-1:0]      dram_dq_out,
   output logic                   dram_dq_oe,
   input  logic [DATA_W-1:0]      dram_dq_in
);
   import pgdram_pkg::*;

   localparam int ADDR_W = ROW_W + COL_W;
   localparam int DA_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int TW     = 16;
   localparam int N_RP   = int'(ns2cyc(T_RP_NS, CLK_NS));
   localparam int N_RCD  = int'(ns2cyc(T_RCD_NS, CLK_NS));
   localparam int N_CAS  = int'(ns2cyc(T_CAS_NS, CLK_NS));
   localparam int N_PC   = int'(ns2cyc(T_PC_NS, CLK_NS));
   localparam int N_CP   = (N_PC > N_CAS) ? (N_PC - N_CAS) : 1;
   localparam int N_RAS  = int'(ns2cyc(T_RC_NS - T_RP_NS, CLK_NS));
   localparam int N_REFI = int'(ns2cyc(T_REFI_NS, CLK_NS));
   localparam int RCW    = $clog2(N_REFI + 1) + 1;

   generate
      if (CLK_NS < 1) begin : g_bad_clk
         $error("CLK_NS must be at least 1");
      end
      if (T_RC_NS <= T_RP_NS) begin : g_bad_rc
         $error("T_RC_NS must exceed T_RP_NS");
      end
      if (T_PC_NS < T_CAS_NS) begin : g_bad_pc
         $error("T_PC_NS must be at least T_CAS_NS");
      end
      if (N_RAS >= 2**TW || N_RP >= 2**TW || N_RCD >= 2**TW) begin : g_bad_tw
         $error("timing counts do not fit the interval timer");
      end
      if (N_REFI <= N_RAS + 2 * N_RP + 8) begin : g_bad_refi
         $error("refresh interval too short for the refresh cycle");
      end
   endgenerate

   pg_state_t         st;
   logic [TW-1:0]     tmr, ras_cnt;
   logic              hv, hwe, cur_rd;
   logic [ROW_W-1:0]  hrow, open_row;
   logic [COL_W-1:0]  hcol;
   logic [DATA_W-1:0] hdat;
   logic              ref_pend, ref_ack, accept, tdone, last_lo;

   assign req_ready = ~hv;
   assign accept    = req_valid & ~hv;
   assign tdone     = (tmr == '0);
   assign ref_ack   = (st == S_IDLE) & ref_pend;
   assign last_lo   = (st == S_CASL) & tdone & cur_rd;

   pgdram_reftick #(.N_REFI(N_REFI), .CW(RCW)) u_tick (
      .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend)
   );

   pgdram_rdcap #(.DATA_W(DATA_W), .EDO(EDO)) u_cap (
      .clk(clk), .rst_n(rst_n), .last_lo(last_lo), .dq_in(dram_dq_in),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   // request holding slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hwe  <= 1'b0;
         hrow <= '0;
         hcol <= '0;
         hdat <= '0;
      end else if (accept) begin
         hwe  <= req_we;
         hrow <= req_addr[ADDR_W-1:COL_W];
         hcol <= req_addr[COL_W-1:0];
         hdat <= req_wdata;
      end
   end

   // cycles the row strobe has been low, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               ras_cnt <= '0;
      else if (dram_ras_n)      ras_cnt <= '0;
      else if (ras_cnt != '1)   ras_cnt <= ras_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         tmr         <= '0;
         hv          <= 1'b0;
         cur_rd      <= 1'b0;
         open_row    <= '0;
         dram_ras_n  <= 1'b1;
         dram_cas_n  <= 1'b1;
         dram_we_n   <= 1'b1;
         dram_oe_n   <= 1'b1;
         dram_addr   <= '0;
         dram_dq_out <= '0;
         dram_dq_oe  <= 1'b0;
      end else begin
         if (accept) hv <= 1'b1;
         if (!tdone) tmr <= tmr - 1'b1;
         unique case (st)
            S_IDLE: begin
               if (ref_pend) begin
                  dram_cas_n <= 1'b0;
                  st         <= S_REFC;
               end else if (hv) begin
                  dram_ras_n <= 1'b0;
                  dram_addr  <= DA_W'(hrow);
                  open_row   <= hrow;
                  tmr        <= TW'(N_RCD - 1);
                  st         <= S_ACT;
               end
            end
            S_ACT: if (tdone) st <= S_OPEN;
            S_OPEN: begin
               if (ref_pend || (hv && hrow != open_row)) begin
                  st <= S_CLOSE;
               end else if (hv) begin
                  if (hwe && dram_we_n) begin
                     dram_we_n <= 1'b0;     // early write: enable before the strobe
                  end else begin
                     dram_cas_n  <= 1'b0;
                     dram_addr   <= DA_W'(hcol);
                     dram_oe_n   <= hwe;
                     dram_dq_out <= hdat;
                     dram_dq_oe  <= hwe;
                     cur_rd      <= ~hwe;
                     hv          <= 1'b0;
                     tmr         <= TW'(N_CAS - 1);
                     st          <= S_CASL;
                  end
               end
            end
            S_CASL: if (tdone) begin
               dram_cas_n <= 1'b1;
               dram_we_n  <= 1'b1;
               tmr        <= TW'(N_CP - 1);
               st         <= S_CASH;
            end
            S_CASH: if (tdone) begin
               dram_oe_n  <= 1'b1;
               dram_dq_oe <= 1'b0;
               st         <= S_OPEN;
            end
            S_CLOSE: begin
               dram_we_n <= 1'b1;
               if (ras_cnt >= TW'(N_RAS - 1)) begin
                  dram_ras_n <= 1'b1;
                  tmr        <= TW'(N_RP - 1);
                  st         <= S_PRE;
               end
            end
            S_PRE: if (tdone) st <= S_IDLE;
            S_REFC: begin
               dram_ras_n <= 1'b0;
               tmr        <= TW'(N_RAS - 1);
               st         <= S_REFR;
            end
            S_REFR: if (tdone) begin
               dram_ras_n <= 1'b1;
               dram_cas_n <= 1'b1;
               tmr        <= TW'(N_RP - 1);
               st         <= S_PRE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pgdram_chk.sv
module pgdram_chk #(
   parameter int N_RP  = 3,
   parameter int N_CAS = 1,
   parameter int N_RAS = 6
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic rd_valid,
   input logic dram_ras_n,
   input logic dram_cas_n,
   input logic dram_we_n,
   input logic dram_oe_n,
   input logic dram_dq_oe
);
   logic [15:0] ras_hi, ras_lo, cas_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_hi <= '1;
         ras_lo <= '0;
         cas_lo <= '0;
      end else begin
         ras_hi <= !dram_ras_n ? '0 : ((ras_hi == '1) ? ras_hi : ras_hi + 1'b1);
         ras_lo <=  dram_ras_n ? '0 : ((ras_lo == '1) ? ras_lo : ras_lo + 1'b1);
         cas_lo <=  dram_cas_n ? '0 : ((cas_lo == '1) ? cas_lo : cas_lo + 1'b1);
      end
   end

   AST_WR_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_cas_n) && !dram_ras_n && !dram_we_n) |-> !$past(dram_we_n)); // R2
   AST_WR_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && !dram_we_n) |-> dram_oe_n); // R2
   AST_DQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> dram_oe_n); // R2
   AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (ras_hi >= 16'(N_RP))); // R4
   AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_cas_n) |-> (cas_lo >= 16'(N_CAS))); // R5
   AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras_n) |-> (ras_lo >= 16'(N_RAS))); // R6
   AST_CBR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_ras_n) && !dram_cas_n) |-> !$past(dram_cas_n)); // R7
   AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R8
   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R9
endmodule

bind pgdram_ctrl pgdram_chk #(.N_RP(N_RP), .N_CAS(N_CAS), .N_RAS(N_RAS)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rd_valid(rd_valid), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
   .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/sim_pgdram_ctrl.sv
`timescale 1ns/1ps
module sim_pgdram_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int ROW_W = 12, COL_W = 10, DW = 16, AW = 22;
   localparam int REFI_NS = 3000;
   // expected cycle counts from the requirement formulas
   localparam int B_RP   = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int B_RCD  = (20 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int B_CAS  = (8 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int B_PC   = (20 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int B_RAS  = (54 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int B_REFI = (REFI_NS + CLK_PERIOD - 1) / CLK_PERIOD;

   // {we, row, col, data, expect_same_row}
   localparam logic [39:0] VEC [12] = '{
      {1'b1, 12'd5,    10'd1,    16'h1111, 1'b0},
      {1'b1, 12'd5,    10'd2,    16'h2222, 1'b1},
      {1'b0, 12'd5,    10'd1,    16'h0000, 1'b1},
      {1'b0, 12'd5,    10'd2,    16'h0000, 1'b1},
      {1'b1, 12'd9,    10'd1023, 16'h3333, 1'b0},
      {1'b0, 12'd5,    10'd1,    16'h0000, 1'b0},
      {1'b0, 12'd9,    10'd1023, 16'h0000, 1'b0},
      {1'b1, 12'd4095, 10'd0,    16'h4444, 1'b0},
      {1'b0, 12'd4095, 10'd0,    16'h0000, 1'b1},
      {1'b0, 12'd7,    10'd7,    16'h0000, 1'b0},
      {1'b1, 12'd7,    10'd7,    16'h5555, 1'b1},
      {1'b0, 12'd7,    10'd7,    16'h0000, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rd_valid;
   logic [DW-1:0] rd_data, dq_out;
   logic [DW-1:0] dq_in = '0;
   logic ras_n, cas_n, we_n, oe_n, dq_oe;
   logic [ROW_W-1:0] dram_addr;

   int total = 0, bad = 0, reads = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgdram_ctrl #(.CLK_NS(CLK_PERIOD), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW),
                 .T_REFI_NS(REFI_NS)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
      .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(dram_addr),
      .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

   function automatic logic [DW-1:0] dflt(input logic [AW-1:0] k);
      return k[DW-1:0] ^ 16'h5A5A;
   endfunction

   // memory model: row on row-strobe fall, column on column-strobe fall
   logic [DW-1:0] mem [logic [AW-1:0]];
   logic [DW-1:0] shadow [logic [AW-1:0]];
   logic [ROW_W-1:0] m_row = '0;
   logic [COL_W-1:0] m_col = '0;
   logic m_we = 1'b1;
   int m_acc = 0;

   always @(negedge ras_n) if (cas_n) m_row = dram_addr;
   always @(negedge cas_n) begin
      if (!ras_n) begin
         m_col = dram_addr[COL_W-1:0];
         m_we  = we_n;
         if (!we_n) mem[{m_row, m_col}] = dq_out;
         else dq_in = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : dflt({m_row, m_col});
         m_acc++;
      end
   end

   // pin monitor, sampled between edges
   int hi_n = 1000, lo_n = 0, casl_n = 0, since_rf = 0, since_cf = 0;
   int min_pre = 1000, min_casl = 1000, min_rasl = 1000, min_rcd = 1000, min_cc = 1000;
   int ras_falls = 0, cbr_cnt = 0, cbr_bad = 0, early_bad = 0, oe_bad = 0, rdv_cnt = 0, cyc = 0;
   bit p_ras = 1, p_cas = 1, p_we = 1, page_first = 1;

   always @(negedge clk) if (rst_n) begin
      cyc++;
      if (p_ras && !ras_n) begin
         if (hi_n < min_pre) min_pre = hi_n;
         if (cas_n) begin ras_falls++; since_rf = 0; page_first = 1; end
         else begin cbr_cnt++; if (p_cas) cbr_bad++; end
         lo_n = 0;
      end
      if (!p_ras && ras_n) begin
         if (lo_n < min_rasl) min_rasl = lo_n;
         hi_n = 0;
      end
      if (p_cas && !cas_n && !ras_n) begin
         if (since_rf < min_rcd) min_rcd = since_rf;
         if (!page_first && since_cf < min_cc) min_cc = since_cf;
         page_first = 0;
         since_cf = 0;
         if (!we_n && p_we) early_bad++;
      end
      if (!p_cas && cas_n && casl_n < min_casl) min_casl = casl_n;
      if (!cas_n && !we_n && !oe_n) oe_bad++;
      if (rd_valid) rdv_cnt++;
      if (ras_n) hi_n++; else lo_n++;
      if (!cas_n) casl_n++; else casl_n = 0;
      since_rf++;
      since_cf++;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_req(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit same_row);
      int nf, nc, na, nr;
      logic [DW-1:0] exp;
      nf = ras_falls; nc = cbr_cnt; na = m_acc; nr = rdv_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R9 ready low after accept", int'(req_ready), 0);
      while (m_acc == na) @(negedge clk);
      chk(m_row == a[AW-1:COL_W], "R1 row on address bus", int'(m_row), int'(a[AW-1:COL_W]));
      chk(m_col == a[COL_W-1:0], "R1 column on address bus", int'(m_col), int'(a[COL_W-1:0]));
      chk(m_we == !we, "R2 write enable level", int'(m_we), int'(!we));
      if (same_row)
         chk(ras_falls == nf || cbr_cnt != nc, "R3 page hit without row strobe", ras_falls - nf, 0);
      else
         chk(ras_falls > nf, "R4 row change reopens", ras_falls - nf, 1);
      if (we) shadow[a] = d;
      else begin
         reads++;
         exp = shadow.exists(a) ? shadow[a] : dflt(a);
         while (rdv_cnt == nr) @(negedge clk);
         chk(rd_data == exp, "R8 read data", int'(rd_data), int'(exp));
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(ras_n && cas_n && we_n && oe_n, "R9 strobes high in reset",
          int'({ras_n, cas_n, we_n, oe_n}), 15);
      chk(!dq_oe && !rd_valid, "R9 data and read strobe idle in reset", int'({dq_oe, rd_valid}), 0);
      chk(req_ready == 1'b1, "R9 ready in reset", int'(req_ready), 1);
      rst_n = 1'b1;

      for (int i = 0; i < 12; i++)
         do_req(VEC[i][39], VEC[i][38:17], VEC[i][16:1], VEC[i][0]);

      // idle span: refresh must keep running and close the open row (R7)
      begin
         int c0;
         c0 = cbr_cnt;
         repeat (2 * B_REFI + 50) @(negedge clk);
         chk(cbr_cnt - c0 >= 2, "R7 refresh during idle", cbr_cnt - c0, 2);
      end
      do_req(1'b0, {12'd7, 10'd7}, 16'h0, 1'b0);   // R7: row was closed by refresh
      do_req(1'b1, {12'd7, 10'd8}, 16'hBEEF, 1'b1);
      do_req(1'b0, {12'd7, 10'd8}, 16'h0, 1'b1);
      repeat (20) @(negedge clk);

      chk(min_pre >= B_RP, "R4 precharge width", min_pre, B_RP);
      chk(min_casl >= B_CAS, "R5 column strobe width", min_casl, B_CAS);
      chk(min_cc >= B_PC, "R5 page cycle", min_cc, B_PC);
      chk(min_rasl >= B_RAS, "R6 row strobe width", min_rasl, B_RAS);
      chk(min_rcd >= B_RCD, "R6 row to column delay", min_rcd, B_RCD);
      chk(cbr_bad == 0, "R7 column before row order", cbr_bad, 0);
      chk(cbr_cnt >= cyc / B_REFI - 1, "R7 refresh rate", cbr_cnt, cyc / B_REFI - 1);
      chk(early_bad == 0, "R2 early write setup", early_bad, 0);
      chk(oe_bad == 0, "R2 output enable off in writes", oe_bad, 0);
      chk(rdv_cnt == reads, "R8 one strobe per read", rdv_cnt, reads);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule